// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block decides, in a single combinational pass, whether a memory access from the load/store unit breaks any of the alignment policies of the two lowest privilege levels. It merges four independent rules. The first is element alignment. The second is 16-byte alignment of the stack pointer when it is used as the base. The third requires that the bytes of a flagged 16-byte atomic access stay inside one naturally aligned 16-byte window. The fourth catches 32-bit-state load/store-multiple to device memory at the user level. A host-routing pair of control bits changes how several of these rules apply.

The unit drives the access address, the access size and element size, the privilege level and the instruction-class flags. The control bits come from the system control state. Two fault flags come back: a general alignment fault and a stack-pointer alignment fault. The stack-pointer fault takes priority, so at most one flag is high. Address translation and exception delivery happen elsewhere.

Top module: `lsu_align_check`

## Requirements
- R1: With `align_en_i` = 1 at level 0 or 1 (`lvl_i` encoding: 0 user, 1 kernel, 2 and 3 higher), an address that is not a multiple of 2^`elem_i` bytes raises `alignment_fault_o`.
- R2: When `host_e2h_i` and `host_tge_i` are both 1, `align_en_i` acts as 0 at both levels 0 and 1.
- R3: At level 1, with `sp_chk_el1_i` = 1 and `sp_base_i` = 1, a nonzero `addr_i[3:0]` raises `sp_alignment_fault_o`. The host pair has no effect on this.
- R4: At level 0, with `sp_chk_el0_i` = 1 and `sp_base_i` = 1, a nonzero `addr_i[3:0]` raises `sp_alignment_fault_o` unless the host pair is {1,1}. When the pair is {1,1} the check is ignored.
- R5: With `atom16_i` = 1 and `unaligned_ok_i` = 0, an access faults with `alignment_fault_o` when `addr_i[3:0]` + 2^`size_i` > 16. With `unaligned_ok_i` = 1 this rule never faults.
- R6: At level 0, with `lsm32_i` = 1, `device_i` = 1 and `lsm_dev_ok_i` = 0, `alignment_fault_o` is raised unless the host pair is {1,1}.
- R7: When a stack-pointer fault and a general fault both apply, only `sp_alignment_fault_o` is raised.
- R8: At levels 2 and 3 neither output is ever raised.
- R9: Encodings of `size_i` and `elem_i` above 4 behave as 4, that is 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Access virtual address |
| size_i | input | 3 | Access size, log2 of bytes |
| elem_i | input | 3 | Element size, log2 of bytes |
| sp_base_i | input | 1 | Base register is the stack pointer |
| lvl_i | input | 2 | Current privilege level |
| atom16_i | input | 1 | Instruction is a 16-byte single-copy-atomic type |
| lsm32_i | input | 1 | 32-bit-state load/store-multiple |
| device_i | input | 1 | Target is device memory |
| align_en_i | input | 1 | General alignment check enable |
| sp_chk_el1_i | input | 1 | Stack-pointer check enable at level 1 |
| sp_chk_el0_i | input | 1 | Stack-pointer check enable at level 0 |
| unaligned_ok_i | input | 1 | Permit 16-byte atomics to cross a window |
| lsm_dev_ok_i | input | 1 | Do not fault multiples to device memory |
| host_e2h_i | input | 1 | Host routing bit, first of pair |
| host_tge_i | input | 1 | Host routing bit, second of pair |
| alignment_fault_o | output | 1 | General alignment fault |
| sp_alignment_fault_o | output | 1 | Stack-pointer alignment fault |

## Verification
The bench sweeps every low-address offset against every size and every control combination. This covers the window edge, where offset plus size equals exactly 16 and must not fault. A checker using `>=` in place of `>` would fault on a full aligned 16-byte access. Host-pair cases show whether the level-0 stack check and the device-multiple rule are suppressed while the level-1 stack check stays active. A design that applied the host override to every rule would miss level-1 stack faults. Cases where both a stack and a general fault apply catch a design that raises both flags. Out-of-range size encodings catch an unclamped shift that wraps the window sum.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  // log2 of the largest granule (16 bytes) used for windows and SP alignment
  localparam int unsigned GRAN_LOG2_MAX = 4;
endpackage

// File: rtl/lsu_gran_misalign.sv
module lsu_gran_misalign #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SZ_W     = 3,
  parameter int unsigned MAX_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   gran_log2_i,
  output logic              misalign_o
);
  logic [MAX_LOG2-1:0] low_hit;

  // one term per low address bit, live when that bit lies under the granule
  for (genvar g = 0; g < MAX_LOG2; g++) begin : g_bit
    assign low_hit[g] = addr_i[g] && (gran_log2_i > SZ_W'(g));
  end

  assign misalign_o = |low_hit;
endmodule

// File: rtl/lsu_window_span.sv
module lsu_window_span #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SZ_W     = 3,
  parameter int unsigned WIN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_log2_i,
  output logic              cross_o
);
  localparam int unsigned SUM_W = WIN_LOG2 + 2;
  localparam logic [SUM_W-1:0] WIN_BYTES = SUM_W'(1) << WIN_LOG2;

  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] bytes;
  logic [SUM_W-1:0] last_plus_one;

  always_comb begin
    offset        = {2'b00, addr_i[WIN_LOG2-1:0]};
    bytes         = SUM_W'(1) << size_log2_i;
    last_plus_one = offset + bytes;
    cross_o       = last_plus_one > WIN_BYTES;
  end
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        elem_i,
  input  logic              sp_base_i,
  input  logic [1:0]        lvl_i,
  input  logic              atom16_i,
  input  logic              lsm32_i,
  input  logic              device_i,
  input  logic              align_en_i,
  input  logic              sp_chk_el1_i,
  input  logic              sp_chk_el0_i,
  input  logic              unaligned_ok_i,
  input  logic              lsm_dev_ok_i,
  input  logic              host_e2h_i,
  input  logic              host_tge_i,
  output logic              alignment_fault_o,
  output logic              sp_alignment_fault_o
);
  localparam int unsigned SZ_W = 3;
  localparam logic [SZ_W-1:0] MAX_ENC = SZ_W'(GRAN_LOG2_MAX);

  lvl_e       lvl;
  logic       host_route;
  logic       at_user;
  logic       at_kernel;
  logic       in_scope;
  logic [2:0] size_c;
  logic [2:0] elem_c;
  logic       elem_mis;
  logic       sp_mis;
  logic       win_cross;
  logic       elem_fault;
  logic       win_fault;
  logic       lsm_fault;
  logic       sp_fault;

  always_comb begin
    lvl        = lvl_e'(lvl_i);
    host_route = host_e2h_i & host_tge_i;
    at_user    = (lvl == LVL_USER);
    at_kernel  = (lvl == LVL_KERNEL);
    in_scope   = at_user | at_kernel;
    size_c     = (size_i > MAX_ENC) ? MAX_ENC : size_i;
    elem_c     = (elem_i > MAX_ENC) ? MAX_ENC : elem_i;
  end

  lsu_gran_misalign #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .MAX_LOG2(GRAN_LOG2_MAX)) u_elem (
    .addr_i      (addr_i),
    .gran_log2_i (elem_c),
    .misalign_o  (elem_mis)
  );

  lsu_gran_misalign #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .MAX_LOG2(GRAN_LOG2_MAX)) u_sp (
    .addr_i      (addr_i),
    .gran_log2_i (MAX_ENC),
    .misalign_o  (sp_mis)
  );

  lsu_window_span #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .WIN_LOG2(GRAN_LOG2_MAX)) u_win (
    .addr_i      (addr_i),
    .size_log2_i (size_c),
    .cross_o     (win_cross)
  );

  always_comb begin
    elem_fault = in_scope & align_en_i & ~host_route & elem_mis;
    win_fault  = in_scope & atom16_i & ~unaligned_ok_i & win_cross;
    lsm_fault  = at_user & lsm32_i & device_i & ~lsm_dev_ok_i & ~host_route;
    sp_fault   = sp_base_i & sp_mis &
                 ((at_kernel & sp_chk_el1_i) | (at_user & sp_chk_el0_i & ~host_route));
    sp_alignment_fault_o = sp_fault;
    alignment_fault_o    = (elem_fault | win_fault | lsm_fault) & ~sp_fault;
  end
endmodule

// File: rtl/lsu_align_check_sva.sv
module lsu_align_check_sva #(
  parameter int unsigned ADDR_W = 16
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        lvl_i,
  input logic              sp_base_i,
  input logic              atom16_i,
  input logic              lsm32_i,
  input logic              host_e2h_i,
  input logic              host_tge_i,
  input logic              alignment_fault_o,
  input logic              sp_alignment_fault_o
);
  always_comb begin
    if (sp_alignment_fault_o)
      a_r7_single_flag: assert (!alignment_fault_o);
    if (lvl_i[1])
      a_r8_upper_quiet: assert (!alignment_fault_o && !sp_alignment_fault_o);
    if (sp_alignment_fault_o)
      a_r3_sp_cause: assert (sp_base_i && (addr_i[3:0] != 4'd0));
    if (host_e2h_i && host_tge_i && lvl_i == 2'd0)
      a_r4_host_user_sp: assert (!sp_alignment_fault_o);
    if (host_e2h_i && host_tge_i && !atom16_i)
      a_r2_host_no_general: assert (!alignment_fault_o);
    if (!atom16_i && !lsm32_i && addr_i[3:0] == 4'd0)
      a_r1_aligned_quiet: assert (!alignment_fault_o);
  end
endmodule

bind lsu_align_check lsu_align_check_sva #(.ADDR_W(ADDR_W)) u_sva (
  .addr_i               (addr_i),
  .lvl_i                (lvl_i),
  .sp_base_i            (sp_base_i),
  .atom16_i             (atom16_i),
  .lsm32_i              (lsm32_i),
  .host_e2h_i           (host_e2h_i),
  .host_tge_i           (host_tge_i),
  .alignment_fault_o    (alignment_fault_o),
  .sp_alignment_fault_o (sp_alignment_fault_o)
);

// File: tb/lsu_align_check_tb.sv
module lsu_align_check_tb;
  localparam int unsigned ADDR_W = 16;

  logic clk;
  logic rst_n;
  logic [ADDR_W-1:0] addr;
  logic [2:0] size, elem;
  logic sp_base, atom16, lsm32, device;
  logic [1:0] lvl;
  logic align_en, sp1, sp0, naa, ldok, e2h, tge;
  logic al_f, sp_f;

  int n_chk;
  int n_bad;
  bit done;

  lsu_align_check #(.ADDR_W(ADDR_W)) u_dut (
    .addr_i (addr), .size_i (size), .elem_i (elem), .sp_base_i (sp_base),
    .lvl_i (lvl), .atom16_i (atom16), .lsm32_i (lsm32), .device_i (device),
    .align_en_i (align_en), .sp_chk_el1_i (sp1), .sp_chk_el0_i (sp0),
    .unaligned_ok_i (naa), .lsm_dev_ok_i (ldok), .host_e2h_i (e2h),
    .host_tge_i (tge), .alignment_fault_o (al_f), .sp_alignment_fault_o (sp_f)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] model();
    int low, e, s;
    bit host, user, kern, gen, spx;
    host = e2h && tge;
    user = (lvl == 2'd0);
    kern = (lvl == 2'd1);
    low  = int'(addr) % 16;
    e    = (elem > 3'd4) ? 4 : int'(elem);
    s    = (size > 3'd4) ? 4 : int'(size);
    gen  = 0;
    if (user || kern) begin
      if (align_en && !host && (int'(addr) % (1 << e)) != 0) gen = 1;   // R1 R2
      if (atom16 && !naa && (low + (1 << s)) > 16) gen = 1;            // R5
      if (user && lsm32 && device && !ldok && !host) gen = 1;           // R6
    end
    spx = sp_base && low != 0 && ((kern && sp1) || (user && sp0 && !host)); // R3 R4
    return {spx, gen && !spx};                                          // R7
  endfunction

  task automatic check(input string req);
    logic [1:0] exp;
    #1;
    exp = model();
    n_chk++;
    if ({sp_f, al_f} !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h size=%0d elem=%0d lvl=%0d ctl=%b%b%b%b%b%b%b flags=%b%b%b%b actual sp/al=%b%b expected=%b%b",
               req, addr, size, elem, lvl, align_en, sp1, sp0, naa, ldok, e2h, tge,
               sp_base, atom16, lsm32, device, sp_f, al_f, exp[1], exp[0]);
    end
  endtask

  task automatic drive_idle();
    addr = '0; size = 3'd0; elem = 3'd0; sp_base = 0; lvl = 2'd0; atom16 = 0;
    lsm32 = 0; device = 0; align_en = 0; sp1 = 0; sp0 = 0; naa = 0; ldok = 0;
    e2h = 0; tge = 0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle quiet");

    // directed corners
    drive_idle(); atom16 = 1; addr = 16'h0000; size = 3'd4; check("R5 full window at edge");
    addr = 16'h0001; check("R5 one past window");
    naa = 1; check("R5 allowed when unaligned ok");
    drive_idle(); lvl = 2'd1; sp1 = 1; sp_base = 1; e2h = 1; tge = 1; addr = 16'h0008;
    check("R3 kernel sp under host pair");
    lvl = 2'd0; sp0 = 1; check("R4 user sp ignored under host pair");
    drive_idle(); align_en = 1; sp1 = 1; sp_base = 1; lvl = 2'd1; addr = 16'h0003; elem = 3'd2;
    check("R7 sp wins");
    drive_idle(); atom16 = 1; addr = 16'h000C; size = 3'd7; check("R9 size clamp");
    drive_idle(); align_en = 1; addr = 16'h0010; elem = 3'd6; check("R9 elem clamp aligned");
    addr = 16'h0018; check("R9 elem clamp misaligned");
    drive_idle(); lvl = 2'd0; lsm32 = 1; device = 1; check("R6 device multiple");
    e2h = 1; tge = 1; check("R6 host suppresses");
    drive_idle(); lvl = 2'd3; align_en = 1; addr = 16'h0007; elem = 3'd3; atom16 = 1; size = 3'd4;
    check("R8 high level quiet");
    drive_idle(); align_en = 1; e2h = 1; tge = 1; addr = 16'h0005; elem = 3'd1; lvl = 2'd1;
    check("R2 host disables enable");

    // sweep: controls x levels x sizes x flags x offsets
    for (int c = 0; c < 128; c++) begin
      for (int l = 0; l < 4; l++) begin
        for (int s = 0; s < 5; s++) begin
          for (int f = 0; f < 16; f++) begin
            for (int o = 0; o < 16; o++) begin
              {align_en, sp1, sp0, naa, ldok, e2h, tge} = 7'(c);
              lvl  = 2'(l);
              size = 3'(s);
              elem = ((f & 1) != 0) ? 3'(4 - s) : 3'(s);
              {sp_base, atom16, lsm32, device} = 4'(f);
              addr = ADDR_W'(((c * 37 + f * 11 + l) * 16) | o);
              check("R1 R2 R3 R4 R5 R6 R7 R8 sweep");
            end
          end
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule